// File: doc/BRIEF.md
# Lockable Control Register Bank with GPIO

This block is a small byte-wide bank of control registers reached through a plain register port: an address, a write strobe with write data, and a read data output that follows the address combinationally. A serial control-bus slave, not part of this block, would normally sit in front of it. The bank holds the device's own bus address and a control bit that turns off output staggering. It also controls two open-drain GPIO pads and reports the levels present on those pads.

A one-way lock bit can freeze the whole bank. Once software sets the lock, every later write is dropped. This includes a write that tries to clear the lock. Only an active-low power-down input, or the chip reset, releases the lock, and either one also returns every register to its default value. The GPIO register mixes two kinds of bit. The drive bits are written by software. The input bits show the pad levels after a two-flop synchronizer and cannot be written.

Top module: `ctrl_regbank`

## Requirements
- R1: While `rst_n` is low, or while `pwdn_n` is low, at a clock edge, the registers return to their defaults. The defaults are: device address equal to `DEV_ADDR_RST` (0x90 by default), stagger-disable 0, both GPIO drive bits 1, and lock 0.
- R2: An unlocked write to address 0x01 stores all 8 data bits as the device address. The new value appears on `dev_addr` and on reads of 0x01 after the write edge.
- R3: Address 0x08 holds the stagger-disable control in bit 3, and `stagger_off` follows that bit. A write to 0x08 ignores all other data bits, and those bits read back as 0.
- R4: Address 0x0D bit 0 is the lock. An unlocked write with data bit 0 set turns the lock on. While the lock is on, writes to any address change nothing, including a write of 0 to 0x0D.
- R5: The lock stays on until `pwdn_n` or `rst_n` is sampled low at a clock edge, and nothing else clears it.
- R6: In register 0x0E, bit 3 is the drive bit for GPIO pin 1 and bit 1 is the drive bit for pin 0. `gpio_pull_low[i]` is 1 exactly when the drive bit for pin i is 0. A drive bit of 1 leaves the pad undriven.
- R7: Reads of 0x0E return the level of pin 1 in bit 2 and the level of pin 0 in bit 0. These levels pass through two flops. A pad change made between edges becomes visible only after the second clock edge that follows it. Writes to these bit positions have no effect.
- R8: Reads of any address other than 0x01, 0x08, 0x0D and 0x0E return 0x00. Writes to those other addresses change no register.
- R9: Bits of 0x0D other than bit 0, and bits 7:4 of 0x0E, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| pwdn_n | input | 1 | Active-low power-down; resets the registers and releases the lock |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| gpio_in | input | N_GPIO | Levels present on the GPIO pads |
| gpio_pull_low | output | N_GPIO | Per-pad pull-down enable; when 0 the pad is high impedance |
| dev_addr | output | 8 | Programmed device bus address |
| stagger_off | output | 1 | Output staggering disabled when 1 |
| cfg_locked | output | 1 | Register bank is locked |

## Verification
Random writes spread over the four mapped registers and over unmapped addresses separate address decode errors from bit-position errors. Writes that carry random data in the bits a register does not implement show whether those bits leak into the register or into read data. The bench sets the lock at random times, sometimes with a data value that leaves bit 0 clear. It also sends power-down pulses at random points. Together these tell apart a lock that is truly sticky from one that can be cleared or re-armed by a write. Directed steps on the pads, checked one edge and then two edges after the change, measure the synchronizer depth exactly.

// File: rtl/crb_pkg.sv
// Package: shared widths, register offsets and bit positions for the control
// register bank. Assumes a byte-wide data path and byte-wide addresses.
package crb_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    // Register offsets. Software decodes these addresses, so they are fixed.
    localparam logic [ADDR_W-1:0] ADDR_DEV  = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_STAG = 8'h08;
    localparam logic [ADDR_W-1:0] ADDR_LOCK = 8'h0D;
    localparam logic [ADDR_W-1:0] ADDR_GPIO = 8'h0E;

    // Bit positions inside the registers.
    localparam int STAG_BIT = 3;
    localparam int LOCK_BIT = 0;

    // Register select, one bit per implemented register.
    typedef struct packed {
        logic dev;
        logic stag;
        logic lock;
        logic gpio;
    } reg_sel_t;
endpackage

// File: rtl/crb_in_sync.sv
// Module: two-flop synchronizer for the GPIO pad input levels.
// Assumes: pads are asynchronous to clk. The output is valid two edges after
// a pad change. Reset clears both stages. The block has one stage pair per pin.
module crb_in_sync #(
    parameter int N_PIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_i,
    output logic [N_PIN-1:0] lvl_o
);
    logic [N_PIN-1:0] stage1_q;
    logic [N_PIN-1:0] stage2_q;
    logic [1:0]       warm_q;

    // Capture the pad levels through two flops, one flop pair per pin.
    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[g] <= 1'b0;
                stage2_q[g] <= 1'b0;
            end else begin
                stage1_q[g] <= pin_i[g];
                stage2_q[g] <= stage1_q[g];
            end
        end
    end

    // Count edges since reset so the latency check looks back only over valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    assign lvl_o = stage2_q;

    // R7: the synchronized level equals the pad level from two edges earlier.
    p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (lvl_o == $past(pin_i, 2)));
endmodule

// File: rtl/crb_lock.sv
// Module: sticky configuration lock.
// Assumes: set_i is already qualified with the write strobe and with "not locked".
// Only rst_n or pwdn_n clears the lock.
module crb_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic pwdn_n,
    input  logic set_i,
    output logic locked_o
);
    // Hold the lock once it is set; clear it only on reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwdn_n) locked_o <= 1'b0;
        else if (set_i)        locked_o <= 1'b1;
    end

    // R4: the lock never drops by itself.
    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n || !pwdn_n)
        locked_o |=> locked_o);

    // R5: power-down releases the lock.
    p_pwdn_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwdn_n |=> !locked_o);
endmodule

// File: rtl/crb_ctl_regs.sv
// Module: storage for the writable fields: device address, stagger-disable
// and the per-pin GPIO drive bits.
// Assumes: wr_ok_i already includes the lock, and the select lines are decoded
// from the address. Drive bit i sits at data bit 2*i+1.
module crb_ctl_regs
    import crb_pkg::*;
#(
    parameter int                N_GPIO       = 2,
    parameter logic [DATA_W-1:0] DEV_ADDR_RST = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwdn_n,
    input  logic              wr_ok_i,
    input  reg_sel_t          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] dev_q,
    output logic              stag_q,
    output logic [N_GPIO-1:0] gout_q
);
    // Load the addressed field on an allowed write; return to defaults on reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwdn_n) begin
            dev_q  <= DEV_ADDR_RST;
            stag_q <= 1'b0;
            gout_q <= '1;
        end else if (wr_ok_i) begin
            if (sel_i.dev)  dev_q  <= wdata_i;
            if (sel_i.stag) stag_q <= wdata_i[STAG_BIT];
            if (sel_i.gpio) begin
                for (int i = 0; i < N_GPIO; i++) gout_q[i] <= wdata_i[2*i+1];
            end
        end
    end

    // R4: without an allowed write, the stored fields do not move.
    p_hold_when_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n || !pwdn_n)
        !wr_ok_i |=> ($stable(dev_q) && $stable(stag_q) && $stable(gout_q)));
endmodule

// File: rtl/ctrl_regbank.sv
// Module: top of the lockable control register bank.
// Assumes: a single-cycle write strobe, combinational read data, and
// N_GPIO <= 4 so that the GPIO register fits in one byte.
// Decodes addresses, applies the lock to writes, builds read data, and drives the pad enables.
module ctrl_regbank
    import crb_pkg::*;
#(
    parameter int                N_GPIO       = 2,
    parameter logic [DATA_W-1:0] DEV_ADDR_RST = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwdn_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_GPIO-1:0] gpio_in,
    output logic [N_GPIO-1:0] gpio_pull_low,
    output logic [DATA_W-1:0] dev_addr,
    output logic              stagger_off,
    output logic              cfg_locked
);
    reg_sel_t          sel;
    logic              unmapped;
    logic              wr_ok;
    logic              lock_set;
    logic [DATA_W-1:0] dev_q;
    logic              stag_q;
    logic [N_GPIO-1:0] gout_q;
    logic [N_GPIO-1:0] gin_s;

    // Decode the address into one select line per implemented register.
    always_comb begin
        sel.dev  = (reg_addr == ADDR_DEV);
        sel.stag = (reg_addr == ADDR_STAG);
        sel.lock = (reg_addr == ADDR_LOCK);
        sel.gpio = (reg_addr == ADDR_GPIO);
        unmapped = !(sel.dev || sel.stag || sel.lock || sel.gpio);
    end

    // Allow writes only while the bank is unlocked.
    assign wr_ok    = reg_wr && !cfg_locked;
    assign lock_set = wr_ok && sel.lock && reg_wdata[LOCK_BIT];

    crb_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwdn_n   (pwdn_n),
        .set_i    (lock_set),
        .locked_o (cfg_locked)
    );

    crb_ctl_regs #(
        .N_GPIO       (N_GPIO),
        .DEV_ADDR_RST (DEV_ADDR_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwdn_n  (pwdn_n),
        .wr_ok_i (wr_ok),
        .sel_i   (sel),
        .wdata_i (reg_wdata),
        .dev_q   (dev_q),
        .stag_q  (stag_q),
        .gout_q  (gout_q)
    );

    crb_in_sync #(
        .N_PIN (N_GPIO)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (gpio_in),
        .lvl_o (gin_s)
    );

    // Build read data; bits that are not implemented, and unmapped addresses, read as 0.
    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            sel.dev:  reg_rdata = dev_q;
            sel.stag: reg_rdata[STAG_BIT] = stag_q;
            sel.lock: reg_rdata[LOCK_BIT] = cfg_locked;
            sel.gpio: begin
                for (int i = 0; i < N_GPIO; i++) begin
                    reg_rdata[2*i+1] = gout_q[i];
                    reg_rdata[2*i]   = gin_s[i];
                end
            end
            default:  reg_rdata = '0;
        endcase
    end

    // Open-drain pads: pull low exactly where the drive bit is 0.
    assign gpio_pull_low = ~gout_q;
    assign dev_addr      = dev_q;
    assign stagger_off   = stag_q;

    // R6: an allowed GPIO write sets each pad enable from its drive bit.
    for (genvar g = 0; g < N_GPIO; g++) begin : g_pad_chk
        p_pad_follow_r6: assert property (@(posedge clk) disable iff (!rst_n || !pwdn_n)
            (reg_wr && sel.gpio && !cfg_locked) |=> (gpio_pull_low[g] == !$past(reg_wdata[2*g+1])));
    end

    // R8: a write to an unmapped address changes no visible state.
    p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n || !pwdn_n)
        (reg_wr && unmapped) |=> ($stable(dev_addr) && $stable(stagger_off)
                                   && $stable(cfg_locked) && $stable(gpio_pull_low)));

    // R3: a write to the stagger register leaves the device address untouched.
    p_stag_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n || !pwdn_n)
        (reg_wr && sel.stag) |=> $stable(dev_addr));
endmodule

// File: tb/ctrl_regbank_tb_top.sv
`timescale 1ns/100ps
module ctrl_regbank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwdn_n = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] gpio_in = 2'b00;
    logic [1:0] gpio_pull_low;
    logic [7:0] dev_addr;
    logic       stagger_off;
    logic       cfg_locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [7:0] m_dev;
    logic       m_stag, m_lock, m_o1, m_o0;
    logic [1:0] h1, h2;

    always #4 clk = ~clk;

    ctrl_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .pwdn_n(pwdn_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpio_in(gpio_in), .gpio_pull_low(gpio_pull_low),
        .dev_addr(dev_addr), .stagger_off(stagger_off), .cfg_locked(cfg_locked)
    );

    // pad level history: two edges of latency, per R7
    always @(posedge clk) begin
        if (!rst_n) begin h1 <= 2'b00; h2 <= 2'b00; end
        else begin h1 <= gpio_in; h2 <= h1; end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h01:   return m_dev;
            8'h08:   return {4'b0, m_stag, 3'b0};
            8'h0D:   return {7'b0, m_lock};
            8'h0E:   return {4'b0, m_o1, h2[1], m_o0, h2[0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_defaults();
        m_dev = 8'h90; m_stag = 1'b0; m_lock = 1'b0; m_o1 = 1'b1; m_o0 = 1'b1;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (!m_lock) begin
            case (a)
                8'h01: m_dev = d;
                8'h08: m_stag = d[3];
                8'h0D: m_lock = d[0];
                8'h0E: begin m_o1 = d[3]; m_o0 = d[1]; end
                default: ;
            endcase
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #0.1;
        model_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pwdn_pulse();
        pwdn_n = 1'b0;
        @(posedge clk); #0.1;
        model_defaults();
        @(negedge clk);
        pwdn_n = 1'b1;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a; #0.5;
        chk(req, reg_rdata, exp);
    endtask

    // full comparison of the outputs and all mapped addresses, plus one unmapped address
    task automatic chk_all(input string req, input logic [7:0] other);
        chk({req, " dev_addr R2"}, dev_addr, m_dev);
        chk({req, " stagger R3"}, stagger_off, m_stag);
        chk({req, " lock R4"}, cfg_locked, m_lock);
        chk({req, " pads R6"}, gpio_pull_low, {~m_o1, ~m_o0});
        rd_chk({req, " rd01 R2"}, 8'h01, exp_rd(8'h01));
        rd_chk({req, " rd08 R3"}, 8'h08, exp_rd(8'h08));
        rd_chk({req, " rd0D R9"}, 8'h0D, exp_rd(8'h0D));
        rd_chk({req, " rd0E R7"}, 8'h0E, exp_rd(8'h0E));
        rd_chk({req, " rdX R8"}, other, exp_rd(other));
    endtask

    function automatic logic [7:0] pick_addr();
        int r = $urandom % 10;
        case (r)
            0, 1: return 8'h01;
            2, 3: return 8'h08;
            4, 5: return 8'h0E;
            default: return 8'($urandom);
        endcase
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        model_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dev default", dev_addr, 8'h90);
        chk("R1 stagger default", stagger_off, 1'b0);
        chk("R1 lock default", cfg_locked, 1'b0);
        chk("R1 pads released", gpio_pull_low, 2'b00);
        rd_chk("R1 gpio read", 8'h0E, 8'h0A);

        // R2 device address
        wr(8'h01, 8'h5C);
        chk("R2 dev_addr", dev_addr, 8'h5C);
        rd_chk("R2 readback", 8'h01, 8'h5C);

        // R3 stagger bit only, other bits ignored
        wr(8'h08, 8'hF7);
        chk("R3 stagger off stays 0", stagger_off, 1'b0);
        rd_chk("R3 other bits zero", 8'h08, 8'h00);
        wr(8'h08, 8'h08);
        chk("R3 stagger off set", stagger_off, 1'b1);
        rd_chk("R3 readback", 8'h08, 8'h08);

        // R6 per-pin drive
        wr(8'h0E, 8'h02);
        chk("R6 pin1 pulls low", gpio_pull_low, 2'b10);
        wr(8'h0E, 8'h08);
        chk("R6 pin0 pulls low", gpio_pull_low, 2'b01);
        wr(8'h0E, 8'hFF);
        chk("R6 both released", gpio_pull_low, 2'b00);

        // R7 synchronizer latency and write-immunity of input bits
        gpio_in = 2'b10;
        idle();
        rd_chk("R7 one edge still old", 8'h0E, 8'h0A);
        idle();
        rd_chk("R7 two edges new pin1", 8'h0E, 8'h0E);
        gpio_in = 2'b01;
        idle(); idle();
        rd_chk("R7 pin0 level", 8'h0E, 8'h0B);
        wr(8'h0E, 8'h0E);
        rd_chk("R7 input bits not writable", 8'h0E, 8'h0B);
        wr(8'h0E, 8'h0A);

        // R8 unmapped addresses
        wr(8'h02, 8'hFF);
        wr(8'h0F, 8'h00);
        chk_all("R8 unmapped write", 8'h02);
        rd_chk("R8 unmapped read", 8'hFF, 8'h00);

        // R9 lock register spare bits
        wr(8'h0D, 8'hFE);
        chk("R9 no lock from spare bits", cfg_locked, 1'b0);
        rd_chk("R9 spare bits zero", 8'h0D, 8'h00);

        // R4 lock and blocking
        wr(8'h0D, 8'h01);
        chk("R4 locked", cfg_locked, 1'b1);
        wr(8'h01, 8'h11);
        wr(8'h08, 8'h00);
        wr(8'h0E, 8'h00);
        wr(8'h0D, 8'h00);
        chk("R4 dev blocked", dev_addr, 8'h5C);
        chk("R4 stagger blocked", stagger_off, 1'b1);
        chk("R4 pads blocked", gpio_pull_low, 2'b00);
        chk("R4 unlock write blocked", cfg_locked, 1'b1);
        rd_chk("R9 lock read", 8'h0D, 8'h01);

        // R5 only power-down clears
        repeat (5) idle();
        chk("R5 lock persists", cfg_locked, 1'b1);
        pwdn_pulse();
        chk("R5 lock cleared", cfg_locked, 1'b0);
        chk("R1 dev after pwdn", dev_addr, 8'h90);
        chk("R1 stagger after pwdn", stagger_off, 1'b0);
        chk_all("R1 after pwdn", 8'h30);

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int r = $urandom % 100;
            gpio_in = 2'($urandom);
            if (r < 3)       pwdn_pulse();
            else if (r < 7)  wr(8'h0D, 8'($urandom));
            else if (r < 12) idle();
            else             wr(pick_addr(), 8'($urandom));
            chk_all("rand", 8'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule